// File: doc/BRIEF.md
# CPU Clock Source and Divide Controller

This block chooses which of four clock sources paces the processor and divides the chosen source by a programmable ratio. The sources are the main oscillator, the PLL output, the fast on-chip oscillator and the low-speed sub clock. Each source arrives as a one-cycle enable pulse on a single fast reference clock. The block produces a processor clock-enable strobe at the divided rate, which the rest of the chip uses in place of a derived clock.

A configuration write loads three things: the source select, a two-bit divide field, and a force-eight bit. While the force-eight bit is 1, the ratio is 8 whatever the field holds. Hardware sets the force-eight bit when stop mode is requested. It also sets the bit when the main oscillator is reported off while main or PLL is the selected source. The sub clock is never divided.

A bus reference strobe runs at the processor strobe's rate and comes out only while its active-low output-enable input is 0. The block has no streaming data path, so every pin is a plain level or pulse, with no valid/ready handshake and no back-pressure.

Top module: `cpu_clk_divctl`

## Requirements
- R1: After reset the selected source is the on-chip oscillator (select code 00), the force-eight bit reads 1, and one processor strobe is produced per 8 on-chip oscillator pulses.
- R2: Only pulses of the selected source advance the divider. Select codes are 00 on-chip oscillator, 01 main, 10 PLL and 11 sub clock, and pulses on the other three inputs have no effect.
- R3: With the force-eight bit at 0 and a main, PLL or on-chip oscillator source, divide field values 00, 01, 10 and 11 give 1, 2, 4 and 16 source pulses per processor strobe.
- R4: With the force-eight bit at 1 and a main, PLL or on-chip oscillator source, the ratio is 8 for every divide field value.
- R5: With the sub clock selected, every sub clock pulse yields a processor strobe on the next cycle, whatever the divide field and force-eight bit hold.
- R6: While stop mode is requested, the force-eight bit reads 1 from the next cycle on.
- R7: While the main oscillator is reported off and the select code is 01 or 10, the force-eight bit reads 1 from the next cycle on. With select code 00 or 11, the main-off flag has no effect on the bit.
- R8: A configuration write of 0 to the force-eight bit has no effect while either forcing condition holds.
- R9: The bus reference strobe pulses in exactly the cycles of the processor strobe while the output-enable input is 0, and it stays low while that input is 1.
- R10: A divide ratio change written mid-period takes effect only after the current period completes at the old ratio. No shortened period is produced.
- R11: A change of source clears the divide counter. The first period on the new source therefore counts a full ratio of that source's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | Main oscillator enable pulse |
| pll_tick | input | 1 | PLL enable pulse |
| oco_tick | input | 1 | Fast on-chip oscillator enable pulse |
| sub_tick | input | 1 | Sub clock enable pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Source select to write (00 on-chip oscillator, 01 main, 10 PLL, 11 sub clock) |
| cfg_div | input | 2 | Divide field to write |
| cfg_force8 | input | 1 | Force-eight bit to write |
| stop_mode | input | 1 | Stop mode request |
| main_off | input | 1 | Main oscillator off flag |
| bclk_oe_n | input | 1 | Bus reference strobe output enable, active low |
| cpu_ce | output | 1 | Processor clock-enable strobe |
| bclk_ce | output | 1 | Bus reference clock-enable strobe |
| force8_rd | output | 1 | Current value of the force-eight bit |

## Verification
The checker watches several rules on every cycle. A processor strobe must follow a selected-source pulse. The divide counter must stay below the active ratio and must clear after a source change. Stop mode and main-off with a main or PLL source must set the force-eight bit on the next cycle. Every sub clock pulse must give a strobe, and the bus strobe must follow the processor strobe and its enable. The period lengths cannot be seen in any single cycle, so only the bench's sweep shows them. That sweep covers every source, field and force-eight combination, and the bench also shows that a ratio change waits for the period to finish and that foreign source pulses are ignored.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  typedef enum logic [1:0] {
    SRC_OCO  = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_SUB  = 2'b11
  } clk_src_e;

  localparam int N_SRC  = 4;
  localparam int LOG2_W = 3;

  // Ratio as a power of two: sub clock 1, forced 8, field 00/01/10/11 -> 1/2/4/16
  function automatic logic [LOG2_W-1:0] ratio_log2(clk_src_e s, logic f8, logic [1:0] fld);
    logic [LOG2_W-1:0] r;
    if (s == SRC_SUB)       r = 3'd0;
    else if (f8)            r = 3'd3;
    else if (fld == 2'b11)  r = 3'd4;
    else                    r = {1'b0, fld};
    return r;
  endfunction

endpackage

// File: rtl/cpu_clk_cfgreg.sv
module cpu_clk_cfgreg
  import cpu_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wr_src,
  input  logic [1:0] wr_div,
  input  logic       wr_f8,
  input  logic       stop_mode,
  input  logic       main_off,
  output clk_src_e   src,
  output logic [1:0] div_fld,
  output logic       force8,
  output logic       src_chg
);

  logic force_hw;
  assign force_hw = stop_mode ||
                    (main_off && (src == SRC_MAIN || src == SRC_PLL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src     <= SRC_OCO;
      div_fld <= 2'b00;
      force8  <= 1'b1;
      src_chg <= 1'b0;
    end else begin
      src_chg <= wr && (clk_src_e'(wr_src) != src);
      if (wr) begin
        src     <= clk_src_e'(wr_src);
        div_fld <= wr_div;
      end
      if (force_hw)  force8 <= 1'b1;
      else if (wr)   force8 <= wr_f8;
    end
  end

endmodule

// File: rtl/cpu_clk_srcmux.sv
module cpu_clk_srcmux
  import cpu_clk_pkg::*;
#(
  parameter int NS = N_SRC,
  localparam int SW = $clog2(NS)
) (
  input  logic [NS-1:0] ticks,
  input  logic [SW-1:0] sel,
  output logic          tick_out
);

  logic [NS-1:0] hit;

  for (genvar i = 0; i < NS; i++) begin : g_sel
    assign hit[i] = ticks[i] && (sel == SW'(i));
  end

  assign tick_out = |hit;

endmodule

// File: rtl/cpu_clk_divcore.sv
module cpu_clk_divcore #(
  parameter int MAX_LOG2 = 4,
  parameter int LW       = 3,
  parameter int RST_LOG2 = 3,
  localparam int CW = MAX_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [LW-1:0] next_log2,
  output logic          ce_next,
  output logic [CW-1:0] cnt,
  output logic [LW-1:0] act_log2
);

  logic [CW:0]   span;
  logic [CW-1:0] last_val;
  logic          term;

  assign span     = (CW+1)'(1) << act_log2;
  assign last_val = CW'(span - (CW+1)'(1));
  assign term     = tick && (cnt == last_val);
  assign ce_next  = term && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_log2 <= LW'(RST_LOG2);
    end else if (restart) begin
      cnt      <= '0;
      act_log2 <= next_log2;
    end else if (term) begin
      cnt      <= '0;
      act_log2 <= next_log2;
    end else if (tick) begin
      cnt      <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/cpu_clk_divctl.sv
module cpu_clk_divctl
  import cpu_clk_pkg::*;
#(
  parameter int MAX_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       pll_tick,
  input  logic       oco_tick,
  input  logic       sub_tick,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_src,
  input  logic [1:0] cfg_div,
  input  logic       cfg_force8,
  input  logic       stop_mode,
  input  logic       main_off,
  input  logic       bclk_oe_n,
  output logic       cpu_ce,
  output logic       bclk_ce,
  output logic       force8_rd
);

  clk_src_e            cur_src;
  logic [1:0]          div_fld;
  logic                force8;
  logic                src_chg;
  logic [N_SRC-1:0]    ticks;
  logic                sel_tick;
  logic                ce_next;
  logic [MAX_LOG2-1:0] core_cnt;
  logic [LOG2_W-1:0]   core_log2;
  logic [LOG2_W-1:0]   next_log2;

  assign ticks = {sub_tick, pll_tick, main_tick, oco_tick};

  cpu_clk_cfgreg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr(cfg_wr), .wr_src(cfg_src), .wr_div(cfg_div), .wr_f8(cfg_force8),
    .stop_mode(stop_mode), .main_off(main_off),
    .src(cur_src), .div_fld(div_fld), .force8(force8), .src_chg(src_chg)
  );

  cpu_clk_srcmux #(.NS(N_SRC)) u_mux (
    .ticks(ticks), .sel(cur_src), .tick_out(sel_tick)
  );

  assign next_log2 = ratio_log2(cur_src, force8, div_fld);

  cpu_clk_divcore #(.MAX_LOG2(MAX_LOG2), .LW(LOG2_W), .RST_LOG2(3)) u_core (
    .clk(clk), .rst_n(rst_n),
    .tick(sel_tick), .restart(src_chg), .next_log2(next_log2),
    .ce_next(ce_next), .cnt(core_cnt), .act_log2(core_log2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_ce  <= 1'b0;
      bclk_ce <= 1'b0;
    end else begin
      cpu_ce  <= ce_next;
      bclk_ce <= ce_next && !bclk_oe_n;
    end
  end

  assign force8_rd = force8;

endmodule

// File: rtl/cpu_clk_divctl_chk.sv
module cpu_clk_divctl_chk #(
  parameter int MAX_LOG2 = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel_tick,
  input logic                src_chg,
  input logic [1:0]          cur_src,
  input logic [MAX_LOG2-1:0] core_cnt,
  input logic [2:0]          core_log2,
  input logic                sub_tick,
  input logic                stop_mode,
  input logic                main_off,
  input logic                bclk_oe_n,
  input logic                cpu_ce,
  input logic                bclk_ce,
  input logic                force8_rd
);

  AST_CE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> $past(sel_tick)); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(core_cnt) < (32'd1 << core_log2))); // R10

  AST_SRCCHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> (core_cnt == '0)); // R11

  AST_STOP_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> force8_rd); // R6

  AST_MAINOFF_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (main_off && (cur_src == 2'b01 || cur_src == 2'b10)) |=> force8_rd); // R7

  AST_SUB_UNDIVIDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src == 2'b11 && sub_tick && !src_chg) |=> cpu_ce); // R5

  AST_BCLK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_ce |-> cpu_ce); // R9

  AST_BCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bclk_oe_n) |-> !bclk_ce); // R9

endmodule

bind cpu_clk_divctl cpu_clk_divctl_chk #(.MAX_LOG2(MAX_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_tick(sel_tick), .src_chg(src_chg),
  .cur_src(cur_src), .core_cnt(core_cnt), .core_log2(core_log2),
  .sub_tick(sub_tick), .stop_mode(stop_mode), .main_off(main_off),
  .bclk_oe_n(bclk_oe_n), .cpu_ce(cpu_ce), .bclk_ce(bclk_ce),
  .force8_rd(force8_rd)
);

// File: tb/cpu_clk_divctl_bench.sv
`timescale 1ns/1ps
module cpu_clk_divctl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ticks = 4'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic [1:0] cfg_div = 2'b00;
  logic cfg_force8 = 1'b0;
  logic stop_mode = 1'b0;
  logic main_off = 1'b0;
  logic bclk_oe_n = 1'b0;
  logic cpu_ce, bclk_ce, force8_rd;

  int per [4];
  int cyc = 0;
  int sel_b = 0;
  int mon_cnt = 0;
  int last_per = 0;
  int ce_cnt = 0;
  int bclk_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cpu_clk_divctl u_cpu_clk_divctl (
    .clk(clk), .rst_n(rst_n),
    .main_tick(ticks[1]), .pll_tick(ticks[2]), .oco_tick(ticks[0]), .sub_tick(ticks[3]),
    .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_force8(cfg_force8),
    .stop_mode(stop_mode), .main_off(main_off), .bclk_oe_n(bclk_oe_n),
    .cpu_ce(cpu_ce), .bclk_ce(bclk_ce), .force8_rd(force8_rd)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    for (int i = 0; i < 4; i++) ticks[i] = (per[i] != 0) && ((cyc % per[i]) == 0);
  end

  always @(negedge clk) begin
    if (cpu_ce) begin
      last_per = mon_cnt;
      mon_cnt  = ticks[sel_b] ? 1 : 0;
      ce_cnt++;
    end else if (ticks[sel_b]) begin
      mon_cnt++;
    end
    if (bclk_ce) bclk_cnt++;
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr_cfg(input int s, input int d, input int f);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_src = 2'(s); cfg_div = 2'(d); cfg_force8 = 1'(f);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic next_period(output int p);
    int c0;
    c0 = ce_cnt;
    while (ce_cnt == c0) @(negedge clk);
    p = last_per;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, exp, c0;
    per[0] = 2; per[1] = 3; per[2] = 1; per[3] = 5;
    sel_b = 0;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(force8_rd, 1, "R1 force-eight after reset");
    next_period(p);
    next_period(p);
    check(p, 8, "R1 reset ratio on on-chip oscillator");

    // Sweep every source, field and force-eight value
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int f = 0; f < 2; f++) begin
          for (int i = 0; i < 4; i++) per[i] = 1 + ((i + s + d + f) % 3);
          wr_cfg(s, d, f);
          sel_b = s;
          if (s == 3)      exp = 1;
          else if (f == 1) exp = 8;
          else if (d == 3) exp = 16;
          else             exp = 1 << d;
          next_period(p);
          next_period(p);
          for (int k = 0; k < 2; k++) begin
            next_period(p);
            if (s == 3)      check(p, exp, "R5 sub clock undivided");
            else if (f == 1) check(p, exp, "R4 forced ratio 8");
            else             check(p, exp, "R3 divide field ratio");
          end
        end

    // R2: foreign pulses ignored
    wr_cfg(0, 1, 0);
    sel_b = 0;
    per[0] = 0; per[1] = 1; per[2] = 1; per[3] = 1;
    cycles(4);
    c0 = ce_cnt;
    cycles(60);
    check(ce_cnt - c0, 0, "R2 unselected pulses ignored");
    per[0] = 1;

    // R9: bus strobe gating
    wr_cfg(0, 1, 0);
    bclk_oe_n = 1'b1;
    cycles(4);
    c0 = bclk_cnt;
    cycles(40);
    check(bclk_cnt - c0, 0, "R9 bus strobe held low when disabled");
    bclk_oe_n = 1'b0;
    cycles(2);
    c0 = bclk_cnt; exp = ce_cnt;
    cycles(40);
    check(bclk_cnt - c0, ce_cnt - exp, "R9 bus strobe matches processor strobe");

    // R6: stop mode forces the bit
    check(force8_rd, 0, "R6 bit clear before stop");
    stop_mode = 1'b1;
    cycles(1);
    @(negedge clk);
    check(force8_rd, 1, "R6 stop mode sets bit");
    wr_cfg(0, 1, 0);
    @(negedge clk);
    check(force8_rd, 1, "R8 write of 0 ignored during stop");
    stop_mode = 1'b0;
    wr_cfg(0, 1, 0);
    @(negedge clk);
    check(force8_rd, 0, "R6 bit writable after stop");

    // R7 / R8: main-off only with main or PLL selected
    main_off = 1'b1;
    cycles(3);
    @(negedge clk);
    check(force8_rd, 0, "R7 main-off ignored with on-chip source");
    wr_cfg(3, 1, 0);
    cycles(2);
    @(negedge clk);
    check(force8_rd, 0, "R7 main-off ignored with sub clock");
    wr_cfg(2, 1, 0);
    cycles(2);
    @(negedge clk);
    check(force8_rd, 1, "R7 main-off forces with PLL");
    wr_cfg(1, 1, 0);
    cycles(2);
    @(negedge clk);
    check(force8_rd, 1, "R8 write of 0 ignored with main off");
    main_off = 1'b0;
    wr_cfg(0, 1, 0);
    @(negedge clk);
    check(force8_rd, 0, "R7 bit clears once main back on");

    // R10: ratio change waits for the period end
    per[0] = 1; sel_b = 0;
    wr_cfg(0, 3, 0);
    next_period(p);
    next_period(p);
    @(posedge clk); #1;
    per[0] = 0;
    cycles(2);
    per[0] = 1;
    cycles(5);
    cfg_wr = 1'b1; cfg_src = 2'd0; cfg_div = 2'd0; cfg_force8 = 1'b0;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    next_period(p);
    check(p, 16, "R10 running period keeps old ratio");
    next_period(p);
    check(p, 1, "R10 new ratio after boundary");

    // R11: source change clears the counter
    wr_cfg(0, 3, 0);
    next_period(p);
    next_period(p);
    per[0] = 1; per[1] = 0;
    cycles(5);
    per[0] = 0;
    wr_cfg(1, 3, 0);
    cycles(3);
    sel_b = 1;
    mon_cnt = 0;
    per[1] = 1;
    next_period(p);
    check(p, 16, "R11 full period after source change");

    finish_run();
  end

endmodule